// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads translation entries from an in-memory table tree that has two levels. The root register gives the frame of the top-level directory. The top ten bits of the virtual address select a directory entry, and the next ten bits select an entry in the second-level table. That table's frame comes from the directory entry. Each table holds 1024 four-byte words, so a table fills one 4 KiB frame.

Every entry used in a walk is checked against the request. The request carries a read-or-write flag and a user-or-supervisor flag. The entry must be present, must grant write access for a write, and must grant user access for a user request. A directory entry with its large-page flag set ends the walk at the first level and maps a 4 MiB region. A walk that succeeds writes back the accessed flag, and for a write also the dirty flag of the leaf. It writes an entry back only when that entry actually changes. A walk that faults writes nothing and reports a cause code.

The block sits between a requester, for example a miss path, and a single-word memory port that uses a request/acknowledge handshake. It handles one walk at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0.
- R2: The directory entry is read at root_frame·4096 + vaddr[31:22]·4. The second-level entry is read at (directory entry bits 31–12)·4096 + vaddr[21:12]·4. A root value loaded between walks applies to the next walk.
- R3: For a small page, the physical address on success is {leaf bits 31–12, vaddr[11:0]}, and `rsp_fault` is 0 with `rsp_cause` 0.
- R4: A directory entry with bit 7 set ends the walk after one read. The physical address is {entry bits 31–22, vaddr[21:0]}.
- R5: An entry with bit 0 (present) clear stops the walk and reports `rsp_fault`=1 with cause 1.
- R6: A write request to an entry with bit 1 clear faults with cause 2. This applies at either level. A read request to the same entry succeeds.
- R7: A user request to an entry with bit 2 clear faults with cause 3. A supervisor request ignores bit 2.
- R8: When several checks fail on one entry, not-present (1) takes priority over privilege (3), and privilege takes priority over write (2).
- R9: On success, bit 5 (accessed) is written back to the directory entry and then to the leaf entry. An entry whose bit 5 is already set is not rewritten.
- R10: A successful write sets bit 6 (dirty) in the leaf entry. For a large page the leaf is the directory entry. A read never sets bit 6, and a small-page walk never sets bit 6 in the directory entry.
- R11: A faulting walk performs no memory writes.
- R12: `mem_req`, `mem_addr` and `mem_we` hold steady until `mem_ack`. `rsp_valid` is a single-cycle pulse. `req_ready` is 1 only while the walker is idle with no memory request open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_load | input | 1 | Load the root directory frame |
| root_frame | input | 20 | Frame number of the top-level directory |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user level, 0 = supervisor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write entry, 0 = read entry |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_ack | input | 1 | Memory has completed the access |
| mem_rdata | input | 32 | Entry read, valid with `mem_ack` |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 0 none, 1 not present, 2 write, 3 privilege |
| rsp_paddr | output | 32 | Physical address on success |

## Verification
The bench builds the walker with its default parameters: a 32-bit address, 12 offset bits and 10-bit indices. This gives a full 1024-entry directory and table, so the bench can reach the entries at index 1023 in both levels as well as the 22-bit large-page offset. The bench memory model counts write-backs. This lets the bench confirm that an entry already marked is left alone, and that a walk which fails at the second level leaves its directory entry untouched. The fault-priority cases place conflicting flags on a single entry.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int FLG_PRESENT = 0;
  localparam int FLG_WRITE   = 1;
  localparam int FLG_USER    = 2;
  localparam int FLG_ACC     = 5;
  localparam int FLG_DIRTY   = 6;
  localparam int FLG_LARGE   = 7;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_ABSENT = 2'd1,
    CAUSE_WRITE  = 2'd2,
    CAUSE_PRIV   = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_RD,
    ST_PTE_RD,
    ST_COMMIT,
    ST_DIR_WB,
    ST_PTE_WB,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int ADDR_W  = 32,
  parameter int FRAME_W = 20,
  parameter int IDX_W   = 10
) (
  input  logic [FRAME_W-1:0] base_frame,
  input  logic [IDX_W-1:0]   index,
  output logic [ADDR_W-1:0]  entry_addr
);
  localparam int SHIFT_W = ADDR_W - FRAME_W;

  logic [ADDR_W-1:0] base_byte;
  logic [ADDR_W-1:0] idx_byte;

  always_comb begin
    base_byte  = {base_frame, {SHIFT_W{1'b0}}};
    idx_byte   = ADDR_W'(index) << 2;
    entry_addr = base_byte + idx_byte;
  end
endmodule

// File: rtl/ptw_perm_chk.sv
module ptw_perm_chk
  import ptw_pkg::*;
(
  input  logic   present,
  input  logic   writable,
  input  logic   user_ok,
  input  logic   is_write,
  input  logic   is_user,
  output logic   fault,
  output cause_e cause
);
  always_comb begin
    if (!present) begin
      fault = 1'b1;
      cause = CAUSE_ABSENT;
    end else if (is_user && !user_ok) begin
      fault = 1'b1;
      cause = CAUSE_PRIV;
    end else if (is_write && !writable) begin
      fault = 1'b1;
      cause = CAUSE_WRITE;
    end else begin
      fault = 1'b0;
      cause = CAUSE_NONE;
    end
  end
endmodule

// File: rtl/ptw_flag_upd.sv
module ptw_flag_upd
  import ptw_pkg::*;
#(
  parameter int ENTRY_W = 32
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic               set_dirty,
  output logic [ENTRY_W-1:0] new_entry,
  output logic               need_wb
);
  always_comb begin
    new_entry = entry;
    new_entry[FLG_ACC] = 1'b1;
    if (set_dirty) new_entry[FLG_DIRTY] = 1'b1;
    need_wb = (new_entry != entry);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       root_load,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] root_frame,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ADDR_W-1:0]          req_vaddr,
  input  logic                       req_write,
  input  logic                       req_user,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [ADDR_W-1:0]          mem_wdata,
  input  logic                       mem_ack,
  input  logic [ADDR_W-1:0]          mem_rdata,
  output logic                       rsp_valid,
  output logic                       rsp_fault,
  output logic [1:0]                 rsp_cause,
  output logic [ADDR_W-1:0]          rsp_paddr
);
  localparam int FRAME_W       = ADDR_W - PAGE_SHIFT;
  localparam int LARGE_OFF_W   = PAGE_SHIFT + IDX_W;
  localparam int LARGE_FRAME_W = ADDR_W - LARGE_OFF_W;

  walk_st_e state_q;

  logic [FRAME_W-1:0] root_q;
  logic [ADDR_W-1:0]  va_q;
  logic               wr_q;
  logic               usr_q;
  logic               large_q;
  logic [ADDR_W-1:0]  dir_q;
  logic [ADDR_W-1:0]  pte_q;
  logic [ADDR_W-1:0]  dir_addr_q;
  logic [ADDR_W-1:0]  pte_addr_q;

  logic               mem_req_q;
  logic               mem_we_q;
  logic [ADDR_W-1:0]  mem_addr_q;
  logic [ADDR_W-1:0]  mem_wdata_q;

  logic               rsp_valid_q;
  logic               rsp_fault_q;
  cause_e             rsp_cause_q;
  logic [ADDR_W-1:0]  rsp_paddr_q;

  // Entry addresses for both levels
  logic [ADDR_W-1:0] dir_addr_n;
  logic [ADDR_W-1:0] pte_addr_n;

  ptw_entry_addr #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_dir_addr (
    .base_frame (root_q),
    .index      (req_vaddr[LARGE_OFF_W +: IDX_W]),
    .entry_addr (dir_addr_n)
  );

  ptw_entry_addr #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_pte_addr (
    .base_frame (mem_rdata[ADDR_W-1 -: FRAME_W]),
    .index      (va_q[PAGE_SHIFT +: IDX_W]),
    .entry_addr (pte_addr_n)
  );

  // Permission check on the word just returned
  logic   chk_fault;
  cause_e chk_cause;

  ptw_perm_chk u_chk (
    .present  (mem_rdata[FLG_PRESENT]),
    .writable (mem_rdata[FLG_WRITE]),
    .user_ok  (mem_rdata[FLG_USER]),
    .is_write (wr_q),
    .is_user  (usr_q),
    .fault    (chk_fault),
    .cause    (chk_cause)
  );

  // Flag updates for write-back
  logic [ADDR_W-1:0] dir_new;
  logic [ADDR_W-1:0] pte_new;
  logic              dir_need;
  logic              pte_need;

  ptw_flag_upd #(.ENTRY_W(ADDR_W)) u_dir_upd (
    .entry     (dir_q),
    .set_dirty (large_q & wr_q),
    .new_entry (dir_new),
    .need_wb   (dir_need)
  );

  ptw_flag_upd #(.ENTRY_W(ADDR_W)) u_pte_upd (
    .entry     (pte_q),
    .set_dirty (wr_q),
    .new_entry (pte_new),
    .need_wb   (pte_need)
  );

  logic              pte_wb_due;
  logic [ADDR_W-1:0] final_paddr;

  always_comb begin
    pte_wb_due = !large_q && pte_need;
    if (large_q)
      final_paddr = {dir_q[ADDR_W-1 -: LARGE_FRAME_W], va_q[LARGE_OFF_W-1:0]};
    else
      final_paddr = {pte_q[ADDR_W-1 -: FRAME_W], va_q[PAGE_SHIFT-1:0]};
  end

  // Root register
  always_ff @(posedge clk) begin
    if (rst) root_q <= '0;
    else if (root_load) root_q <= root_frame;
  end

  // Walk controller
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      wr_q        <= 1'b0;
      usr_q       <= 1'b0;
      large_q     <= 1'b0;
      dir_q       <= '0;
      pte_q       <= '0;
      dir_addr_q  <= '0;
      pte_addr_q  <= '0;
      mem_req_q   <= 1'b0;
      mem_we_q    <= 1'b0;
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_cause_q <= CAUSE_NONE;
      rsp_paddr_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q       <= req_vaddr;
            wr_q       <= req_write;
            usr_q      <= req_user;
            large_q    <= 1'b0;
            dir_addr_q <= dir_addr_n;
            mem_req_q  <= 1'b1;
            mem_we_q   <= 1'b0;
            mem_addr_q <= dir_addr_n;
            state_q    <= ST_DIR_RD;
          end
        end

        ST_DIR_RD: begin
          if (mem_ack) begin
            dir_q <= mem_rdata;
            if (chk_fault) begin
              mem_req_q   <= 1'b0;
              rsp_valid_q <= 1'b1;
              rsp_fault_q <= 1'b1;
              rsp_cause_q <= chk_cause;
              rsp_paddr_q <= '0;
              state_q     <= ST_DONE;
            end else if (mem_rdata[FLG_LARGE]) begin
              large_q   <= 1'b1;
              mem_req_q <= 1'b0;
              state_q   <= ST_COMMIT;
            end else begin
              pte_addr_q <= pte_addr_n;
              mem_addr_q <= pte_addr_n;
              state_q    <= ST_PTE_RD;
            end
          end
        end

        ST_PTE_RD: begin
          if (mem_ack) begin
            pte_q     <= mem_rdata;
            mem_req_q <= 1'b0;
            if (chk_fault) begin
              rsp_valid_q <= 1'b1;
              rsp_fault_q <= 1'b1;
              rsp_cause_q <= chk_cause;
              rsp_paddr_q <= '0;
              state_q     <= ST_DONE;
            end else begin
              state_q <= ST_COMMIT;
            end
          end
        end

        ST_COMMIT: begin
          if (dir_need) begin
            mem_req_q   <= 1'b1;
            mem_we_q    <= 1'b1;
            mem_addr_q  <= dir_addr_q;
            mem_wdata_q <= dir_new;
            state_q     <= ST_DIR_WB;
          end else if (pte_wb_due) begin
            mem_req_q   <= 1'b1;
            mem_we_q    <= 1'b1;
            mem_addr_q  <= pte_addr_q;
            mem_wdata_q <= pte_new;
            state_q     <= ST_PTE_WB;
          end else begin
            rsp_valid_q <= 1'b1;
            rsp_fault_q <= 1'b0;
            rsp_cause_q <= CAUSE_NONE;
            rsp_paddr_q <= final_paddr;
            state_q     <= ST_DONE;
          end
        end

        ST_DIR_WB: begin
          if (mem_ack) begin
            if (pte_wb_due) begin
              mem_addr_q  <= pte_addr_q;
              mem_wdata_q <= pte_new;
              state_q     <= ST_PTE_WB;
            end else begin
              mem_req_q   <= 1'b0;
              mem_we_q    <= 1'b0;
              rsp_valid_q <= 1'b1;
              rsp_fault_q <= 1'b0;
              rsp_cause_q <= CAUSE_NONE;
              rsp_paddr_q <= final_paddr;
              state_q     <= ST_DONE;
            end
          end
        end

        ST_PTE_WB: begin
          if (mem_ack) begin
            mem_req_q   <= 1'b0;
            mem_we_q    <= 1'b0;
            rsp_valid_q <= 1'b1;
            rsp_fault_q <= 1'b0;
            rsp_cause_q <= CAUSE_NONE;
            rsp_paddr_q <= final_paddr;
            state_q     <= ST_DONE;
          end
        end

        ST_DONE: begin
          state_q <= ST_IDLE;
        end

        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mem_req   = mem_req_q;
  assign mem_we    = mem_we_q;
  assign mem_addr  = mem_addr_q;
  assign mem_wdata = mem_wdata_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_fault = rsp_fault_q;
  assign rsp_cause = rsp_cause_q;
  assign rsp_paddr = rsp_paddr_q;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              wb_acc,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [1:0]        rsp_cause
);
  a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r12_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req);

  a_r5_fault_cause: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_cause != 2'd0);

  a_r3_ok_cause: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_fault |-> rsp_cause == 2'd0);

  a_r9_wb_marks: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> wb_acc);
endmodule

bind pt_walker ptw_checker #(.ADDR_W(ADDR_W)) u_ptw_checker (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_ack   (mem_ack),
  .wb_acc    (mem_wdata[ptw_pkg::FLG_ACC]),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .rsp_cause (rsp_cause)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        root_load = 1'b0;
  logic [19:0] root_frame = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        rsp_valid, rsp_fault;
  logic [1:0]  rsp_cause;
  logic [31:0] rsp_paddr;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  bit done = 1'b0;

  logic [31:0] store [logic [31:0]];
  logic [34:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst(rst), .root_load(root_load), .root_frame(root_frame),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .rsp_paddr(rsp_paddr)
  );

  // Memory model: one access served per request, acknowledged a cycle later
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
  end
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        store[mem_addr] = mem_wdata;
        wr_cnt++;
      end else begin
        mem_rdata <= store.exists(mem_addr) ? store[mem_addr] : 32'h0;
      end
    end
  end

  function automatic logic [31:0] peek(input logic [31:0] a);
    return store.exists(a) ? store[a] : 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected results and checks the one-cycle pulse
  bit prev_valid = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_valid) check("R12 rsp pulse width", {31'd0, rsp_valid}, 32'd0);
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          check("R12 unexpected response", 32'd1, 32'd0);
        end else begin
          logic [34:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({t, " fault"}, {31'd0, rsp_fault}, {31'd0, e[34]});
          check({t, " cause"}, {30'd0, rsp_cause}, {30'd0, e[33:32]});
          if (!e[34]) check({t, " paddr"}, rsp_paddr, e[31:0]);
        end
      end
      prev_valid <= rsp_valid;
    end
  end

  task automatic xlate(input string tag, input logic [31:0] va, input bit wr, input bit usr,
                       input bit f, input logic [1:0] c, input logic [31:0] pa);
    exp_q.push_back({f, c, pa});
    tag_q.push_back(tag);
    @(negedge clk);
    req_vaddr = va;
    req_write = wr;
    req_user  = usr;
    req_valid = 1'b1;
    do @(posedge clk); while (!req_ready);
    @(negedge clk);
    req_valid = 1'b0;
    check("R12 ready low while busy", {31'd0, req_ready}, 32'd0);
    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic writes_since(input string tag, input int base, input int exp_n);
    check(tag, wr_cnt - base, exp_n);
  endtask

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", {31'd0, req_ready}, 32'd1);
    check("R1 no response after reset", {31'd0, rsp_valid}, 32'd0);
    check("R1 no memory request after reset", {31'd0, mem_req}, 32'd0);

    root_frame = 20'h00010;
    root_load = 1'b1;
    @(negedge clk);
    root_load = 1'b0;

    // Small page, supervisor read, user bit clear is ignored (R7)
    store[32'h10004] = 32'h0002_0003;
    store[32'h20004] = 32'h1234_5003;
    w0 = wr_cnt;
    xlate("R3 small read", 32'h0040_1ABC, 0, 0, 0, 2'd0, 32'h1234_5ABC);
    check("R9 dir accessed", peek(32'h10004), 32'h0002_0023);
    check("R9 leaf accessed no dirty R10", peek(32'h20004), 32'h1234_5023);
    writes_since("R9 two write-backs", w0, 2);

    w0 = wr_cnt;
    xlate("R9 repeat read", 32'h0040_1ABC, 0, 0, 0, 2'd0, 32'h1234_5ABC);
    writes_since("R9 no rewrite when marked", w0, 0);

    w0 = wr_cnt;
    xlate("R10 small write", 32'h0040_1ABC, 1, 0, 0, 2'd0, 32'h1234_5ABC);
    check("R10 leaf dirty", peek(32'h20004), 32'h1234_5063);
    check("R10 dir not dirty", peek(32'h10004), 32'h0002_0023);
    writes_since("R10 one write-back", w0, 1);

    // Large page, user write
    store[32'h100C8] = 32'h48C0_0087;
    w0 = wr_cnt;
    xlate("R4 large write", 32'h0C80_1234, 1, 1, 0, 2'd0, 32'h48C0_1234);
    check("R4 large entry marked", peek(32'h100C8), 32'h48C0_00E7);
    writes_since("R4 single write-back", w0, 1);

    // Not present at directory and at leaf
    w0 = wr_cnt;
    xlate("R5 dir absent", 32'h0140_0000, 0, 0, 1, 2'd1, 32'h0);
    writes_since("R11 no write on dir fault", w0, 0);
    store[32'h10018] = 32'h0002_1003;
    w0 = wr_cnt;
    xlate("R5 leaf absent", 32'h0180_0010, 0, 0, 1, 2'd1, 32'h0);
    check("R11 dir untouched", peek(32'h10018), 32'h0002_1003);
    writes_since("R11 no write on leaf fault", w0, 0);

    // Write violation at leaf
    store[32'h1001C] = 32'h0002_2007;
    store[32'h22000] = 32'h5555_5005;
    w0 = wr_cnt;
    xlate("R6 leaf read-only write", 32'h01C0_0000, 1, 0, 1, 2'd2, 32'h0);
    writes_since("R11 no write on write fault", w0, 0);
    xlate("R6 leaf read-only read", 32'h01C0_0000, 0, 0, 0, 2'd0, 32'h5555_5000);

    // Privilege
    store[32'h10020] = 32'h0002_3007;
    store[32'h23000] = 32'h6666_6003;
    xlate("R7 user to supervisor page", 32'h0200_0004, 0, 1, 1, 2'd3, 32'h0);
    xlate("R7 supervisor ignores user bit", 32'h0200_0004, 0, 0, 0, 2'd0, 32'h6666_6004);

    // Priority
    store[32'h10024] = 32'h0002_4007;
    store[32'h24000] = 32'h7777_7000;
    xlate("R8 absent beats others", 32'h0240_0000, 1, 1, 1, 2'd1, 32'h0);
    store[32'h24000] = 32'h7777_7001;
    xlate("R8 privilege beats write", 32'h0240_0000, 1, 1, 1, 2'd3, 32'h0);

    // Write violation at directory level
    store[32'h10028] = 32'h0002_7005;
    store[32'h27000] = 32'h8888_8007;
    xlate("R6 dir read-only write", 32'h0280_0000, 1, 1, 1, 2'd2, 32'h0);
    xlate("R6 dir read-only read", 32'h0280_0000, 0, 1, 0, 2'd0, 32'h8888_8000);

    // Last index of both tables
    store[32'h10FFC] = 32'h0002_5003;
    store[32'h25FFC] = 32'hABCD_E003;
    xlate("R2 top indices", 32'hFFFF_F123, 0, 0, 0, 2'd0, 32'hABCD_E123);

    // New root
    @(negedge clk);
    root_frame = 20'h00030;
    root_load = 1'b1;
    @(negedge clk);
    root_load = 1'b0;
    store[32'h30004] = 32'h0002_6003;
    store[32'h26004] = 32'h1357_9003;
    xlate("R2 reloaded root", 32'h0040_1000, 0, 0, 0, 2'd0, 32'h1357_9000);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R12 actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule